// File: doc/BRIEF.md
# Serial Converter Frame-Strobe Controller

This block is the host side of a serial link to a data converter. The converter's port has two active-low frame strobes, one for receive and one for transmit. It also has an address-select line and an active-low data-ready flag. The controller accepts one-cycle read and write requests on a parallel interface and generates the serial clock, the strobes and the address line. It shifts three bytes per frame, most significant bit first, and returns a 24-bit word together with a single-cycle completion pulse.

A read waits until the converter reports data ready. It then lowers the receive strobe and clocks in one byte. Before each further byte it checks the data-ready flag again, and the receive strobe stays low while it waits. A write lowers the transmit strobe and the address-select line together, waits one half-period of the serial clock for setup, then shifts out the 24-bit control word. The serial clock idles high. Its half-period is a parameter counted in system clocks. Data is launched on the falling edge and sampled on the rising edge.

Top module: `sadc_frame_ctrl`

## Requirements
- R1: After reset and whenever `busy` is low, `rxfs_n`, `txfs_n`, `asel` and `sclk` are all high.
- R2: After a read request, `rxfs_n` falls only on the clock after `drdy_n` has been sampled low. While `drdy_n` stays high, `rxfs_n` and `sclk` stay high.
- R3: `rxfs_n` stays low from the first serial-clock fall of a read until the 24th rising edge. It is high again before `done`, and each read produces exactly one strobe frame and 24 `sclk` falls.
- R4: The first bit received lands in `rd_word[23]` and the last in `rd_word[0]`.
- R5: During a write, `txfs_n` and `asel` fall in the same cycle and rise in the same cycle. `rxfs_n` is never low while `txfs_n` is low, and a write produces 24 `sclk` falls.
- R6: `sdo` carries `wr_word` MSB first. It changes on the `sclk` fall and is stable at the following rise.
- R7: Before every byte of a read, `drdy_n` is checked again. If it is high after a byte, `sclk` stays high and `rxfs_n` stays low until `drdy_n` returns low.
- R8: `sclk` changes only inside a frame, and each `sclk` low phase lasts `HALF_DIV` system clocks.
- R9: Requests are accepted only while `busy` is low, and a request made while busy is ignored without being queued. If `rd_req` and `wr_req` are high in the same cycle, the read is taken.
- R10: `done` is high for exactly one cycle, the first idle cycle after a transfer, and `busy` is low in that cycle.
- R11: `rd_word` changes only in the cycle in which `done` is high after a read. Writes leave it unchanged.
- R12: `asel` stays high throughout a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Start a read of the converter result |
| wr_req | input | 1 | Start a write of `wr_word` |
| wr_word | input | 24 | Control word to send |
| drdy_n | input | 1 | Converter data-ready, active low |
| sdi | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles high |
| rxfs_n | output | 1 | Receive frame strobe, active low |
| txfs_n | output | 1 | Transmit frame strobe, active low |
| asel | output | 1 | Address select, low only during writes |
| sdo | output | 1 | Serial data to the converter |
| rd_word | output | 24 | Last received word |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while a transfer is pending or active |

## Verification
On every cycle, the assertions check the idle levels of the strobes, and that a receive frame never opens unless data-ready was low. They also check that the two frames never overlap, that the serial clock moves only inside a frame, the width of the completion pulse, and that the received word changes only with it. The bench's scenarios are needed to show the bit order in both directions, the exact bit and frame counts, the pause between bytes, the low-phase length of the serial clock, and how requests made while busy or in the same cycle are treated.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RPEND  = 3'd1,
    ST_RSHIFT = 3'd2,
    ST_RGAP   = 3'd3,
    ST_WSETUP = 3'd4,
    ST_WSHIFT = 3'd5,
    ST_DONE   = 3'd6
  } sadc_state_e;
endpackage

// File: rtl/sadc_sclk_div.sv
module sadc_sclk_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (cnt_q == CNT_LAST)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == CNT_LAST);

  // R8: the half-period counter never passes its limit
  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
endmodule

// File: rtl/sadc_shift.sv
module sadc_shift #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              launch,
  input  logic              sample,
  input  logic              sdi,
  output logic              sdo,
  output logic [WORD_W-1:0] rx
);
  logic [WORD_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic              sdo_q, sdo_d;

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_q;
    sdo_d = sdo_q;
    if (load)
      tx_d = load_val;
    else if (launch) begin
      sdo_d = tx_q[WORD_W-1];
      tx_d  = {tx_q[WORD_W-2:0], 1'b0};
    end
    if (sample)
      rx_d = {rx_q[WORD_W-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      sdo_q <= sdo_d;
    end
  end

  assign sdo = sdo_q;
  assign rx  = rx_q;

  // R6: the output bit moves only on a launch
  p_sdo_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(launch));
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int N_BYTES = 3,
  parameter int BYTE_W  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic        wr_req,
  input  logic        drdy_n,
  input  logic        tick,
  output sadc_state_e state,
  output logic        load,
  output logic        launch,
  output logic        sample,
  output logic        capture,
  output logic        sclk,
  output logic        done
);
  localparam int BIT_W  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int BYTE_CW = $clog2(N_BYTES + 1);
  localparam logic [BIT_W-1:0]   BIT_LAST  = BIT_W'(BYTE_W - 1);
  localparam logic [BYTE_CW-1:0] BYTE_LAST = BYTE_CW'(N_BYTES - 1);

  sadc_state_e          state_q, state_d;
  logic                 phase_q, phase_d;
  logic [BIT_W-1:0]     bit_q, bit_d;
  logic [BYTE_CW-1:0]   byte_q, byte_d;
  logic                 is_rd_q, is_rd_d;
  logic                 sclk_q, sclk_d;
  logic                 done_q, done_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    is_rd_d = is_rd_q;
    sclk_d  = sclk_q;
    done_d  = 1'b0;
    load    = 1'b0;
    launch  = 1'b0;
    sample  = 1'b0;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (rd_req) begin
          state_d = ST_RPEND;
          is_rd_d = 1'b1;
        end else if (wr_req) begin
          state_d = ST_WSETUP;
          is_rd_d = 1'b0;
          load    = 1'b1;
        end
      end
      ST_RPEND, ST_RGAP: begin
        if (!drdy_n) state_d = ST_RSHIFT;
      end
      ST_WSETUP: begin
        if (tick) state_d = ST_WSHIFT;
      end
      ST_RSHIFT, ST_WSHIFT: begin
        if (tick) begin
          if (!phase_q) begin
            launch  = 1'b1;
            sclk_d  = 1'b0;
            phase_d = 1'b1;
          end else begin
            sample  = 1'b1;
            sclk_d  = 1'b1;
            phase_d = 1'b0;
            if (bit_q == BIT_LAST) begin
              bit_d = '0;
              if (byte_q == BYTE_LAST) begin
                byte_d  = '0;
                state_d = ST_DONE;
              end else begin
                byte_d = byte_q + 1'b1;
                if (state_q == ST_RSHIFT) state_d = ST_RGAP;
              end
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
        capture = is_rd_q;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      bit_q   <= '0;
      byte_q  <= '0;
      is_rd_q <= 1'b0;
      sclk_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      is_rd_q <= is_rd_d;
      sclk_q  <= sclk_d;
      done_q  <= done_d;
    end
  end

  assign state = state_q;
  assign sclk  = sclk_q;
  assign done  = done_q;

  // R10: completion pulse lasts one cycle and lands in idle
  p_done_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE));
  // R7: a byte of a read begins only from a sampled-low ready flag
  p_byte_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_RGAP && state_q == ST_RSHIFT) |-> $past(!drdy_n));
endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl
  import sadc_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int N_BYTES  = 3,
  parameter int BYTE_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_req,
  input  logic                        wr_req,
  input  logic [N_BYTES*BYTE_W-1:0]   wr_word,
  input  logic                        drdy_n,
  input  logic                        sdi,
  output logic                        sclk,
  output logic                        rxfs_n,
  output logic                        txfs_n,
  output logic                        asel,
  output logic                        sdo,
  output logic [N_BYTES*BYTE_W-1:0]   rd_word,
  output logic                        done,
  output logic                        busy
);
  localparam int WORD_W = N_BYTES * BYTE_W;

  sadc_state_e       state;
  logic              tick, run, load, launch, sample, capture;
  logic [WORD_W-1:0] rx;
  logic [WORD_W-1:0] rd_word_q, rd_word_d;

  assign run = (state == ST_WSETUP) || (state == ST_RSHIFT) || (state == ST_WSHIFT);

  sadc_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  sadc_seq #(.N_BYTES(N_BYTES), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .drdy_n(drdy_n), .tick(tick), .state(state), .load(load),
    .launch(launch), .sample(sample), .capture(capture),
    .sclk(sclk), .done(done)
  );

  sadc_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(wr_word),
    .launch(launch), .sample(sample), .sdi(sdi), .sdo(sdo), .rx(rx)
  );

  always_comb begin
    rd_word_d = rd_word_q;
    if (capture) rd_word_d = rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_word_q <= '0;
    else        rd_word_q <= rd_word_d;
  end

  assign rd_word = rd_word_q;
  assign rxfs_n  = !((state == ST_RSHIFT) || (state == ST_RGAP));
  assign txfs_n  = !((state == ST_WSETUP) || (state == ST_WSHIFT));
  assign asel    = txfs_n;
  assign busy    = (state != ST_IDLE);

  // R1: idle levels on the port
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rxfs_n && txfs_n && asel && sclk));
  // R2: receive frame opens only after ready was sampled low
  p_rd_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxfs_n) |-> $past(!drdy_n));
  // R5: frames never overlap
  p_wr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !txfs_n |-> rxfs_n);
  // R8: serial clock moves only inside a frame
  p_sclk_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> $past(!rxfs_n || !txfs_n));
  // R11: received word changes only with the completion pulse
  p_word_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_word) |-> done);
  // R12: address select stays high while receiving
  p_asel_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rxfs_n |-> asel);
endmodule

// File: tb/tb_sadc_frame_ctrl.sv
`timescale 1ns/1ps
module tb_sadc_frame_ctrl;
  localparam int HALF_DIV = 2;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n, rd_req, wr_req, drdy_n;
  logic [W-1:0] wr_word;
  logic sdi, sclk, rxfs_n, txfs_n, asel, sdo, done, busy;
  logic [W-1:0] rd_word;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  sadc_frame_ctrl #(.HALF_DIV(HALF_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .wr_word(wr_word), .drdy_n(drdy_n), .sdi(sdi), .sclk(sclk),
    .rxfs_n(rxfs_n), .txfs_n(txfs_n), .asel(asel), .sdo(sdo),
    .rd_word(rd_word), .done(done), .busy(busy)
  );

  // converter model and port monitors
  logic [W-1:0] conv_word;
  int rx_idx, fall_cnt, rise_cnt, rx_frames, tx_frames, tx_bits;
  logic [W-1:0] cap;
  logic txf_d;
  bit bad_asel, bad_pair;
  time t_fall, low_dur;

  assign sdi = (rx_idx < W) ? conv_word[W-1-rx_idx] : 1'b0;
  always @(posedge clk) txf_d <= txfs_n;
  always @(posedge sclk) begin
    rise_cnt <= rise_cnt + 1;
    low_dur  <= $time - t_fall;
    if (!rxfs_n) rx_idx <= rx_idx + 1;
    if (!txf_d) begin
      cap     <= {cap[W-2:0], sdo};
      tx_bits <= tx_bits + 1;
    end
  end
  always @(negedge sclk) begin
    fall_cnt <= fall_cnt + 1;
    t_fall   <= $time;
  end
  always @(negedge rxfs_n) rx_frames <= rx_frames + 1;
  always @(negedge txfs_n) tx_frames <= tx_frames + 1;
  always @(negedge clk) begin
    if (!rxfs_n && !asel) bad_asel <= 1'b1;
    if (txfs_n != asel)   bad_pair <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rx_idx = 0; fall_cnt = 0; rise_cnt = 0; rx_frames = 0;
    tx_frames = 0; tx_bits = 0; cap = '0; bad_asel = 0; bad_pair = 0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wait_done();
    while (!done) begin
      @(negedge clk);
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  endtask

  task automatic pulse(input bit rd, input bit wr, input logic [W-1:0] d);
    @(negedge clk);
    rd_req = rd; wr_req = wr; wr_word = d;
    @(negedge clk);
    rd_req = 0; wr_req = 0;
  endtask

  // bit 24 set marks a write; otherwise a read of the pattern
  localparam logic [W:0] VEC [0:5] = '{
    25'h0_A5C3_96, 25'h1_80_0001, 25'h0_00_0001,
    25'h1_3C_5AF0, 25'h0_FF_FFFE, 25'h1_7E_8181
  };

  logic [W-1:0] last_rd;

  initial begin
    rst_n = 0; rd_req = 0; wr_req = 0; drdy_n = 1; wr_word = '0;
    conv_word = '0; t_fall = 0; low_dur = 0;
    clear_mon();
    repeat (3) @(negedge clk);
    // R1: reset levels
    chk(rxfs_n && txfs_n && asel && sclk && !busy && !done, "R1 reset levels",
        {rxfs_n, txfs_n, asel, sclk, busy, done}, 6'b111100);
    rst_n = 1;
    @(negedge clk);
    drdy_n = 0;

    for (int i = 0; i < 6; i++) begin
      clear_mon();
      if (VEC[i][W]) begin
        pulse(0, 1, VEC[i][W-1:0]);
        wait_done();
        chk(!busy, "R10 busy low with done", busy, 0);
        chk(cap == VEC[i][W-1:0], "R6 write bits MSB first", cap, VEC[i][W-1:0]);
        chk(!bad_pair && tx_frames == 1 && tx_bits == W && fall_cnt == W,
            "R5 write strobe and address pairing", tx_bits, W);
        chk(rd_word == last_rd, "R11 word held across write", rd_word, last_rd);
        @(negedge clk);
        chk(!done, "R10 done one cycle", done, 0);
        chk(rxfs_n && txfs_n && asel && sclk, "R1 idle after write",
            {rxfs_n, txfs_n, asel, sclk}, 4'hF);
      end else begin
        conv_word = VEC[i][W-1:0];
        pulse(1, 0, '0);
        wait_done();
        last_rd = VEC[i][W-1:0];
        chk(rd_word == last_rd, "R4 read word MSB in bit 23", rd_word, last_rd);
        chk(rx_frames == 1 && fall_cnt == W && rxfs_n, "R3 single 24-bit frame",
            fall_cnt, W);
        chk(!bad_asel, "R12 asel high during read", bad_asel, 0);
        chk(low_dur == HALF_DIV * 4, "R8 sclk low phase", low_dur, HALF_DIV * 4);
        @(negedge clk);
        chk(!done, "R10 done one cycle", done, 0);
      end
    end

    // R2: read waits for ready
    clear_mon();
    drdy_n = 1;
    conv_word = 24'h5A_1234;
    pulse(1, 0, '0);
    repeat (40) @(negedge clk);
    chk(rxfs_n && fall_cnt == 0 && busy, "R2 wait while not ready", fall_cnt, 0);
    drdy_n = 0;
    wait_done();
    chk(rd_word == 24'h5A_1234, "R2 read after ready", rd_word, 24'h5A1234);

    // R7: pause between bytes
    clear_mon();
    conv_word = 24'hC0_FFEE;
    pulse(1, 0, '0);
    wait (rise_cnt == 8);
    #1 drdy_n = 1;
    repeat (30) @(negedge clk);
    chk(fall_cnt == 8 && !rxfs_n && sclk, "R7 stall between bytes", fall_cnt, 8);
    drdy_n = 0;
    wait_done();
    chk(rd_word == 24'hC0_FFEE && rx_frames == 1, "R7 read resumes", rd_word, 24'hC0FFEE);

    // R9: simultaneous requests take the read; busy requests ignored
    clear_mon();
    conv_word = 24'h13_579B;
    pulse(1, 1, 24'hFFFFFF);
    repeat (10) @(negedge clk);
    pulse(0, 1, 24'hABCDEF);
    pulse(1, 0, '0);
    wait_done();
    chk(rd_word == 24'h13_579B, "R9 read wins", rd_word, 24'h13579B);
    repeat (8) @(negedge clk);
    chk(tx_frames == 0 && rx_frames == 1 && !busy, "R9 busy requests ignored",
        tx_frames, 0);

    finish_run();
  end

  initial begin
    #700000;
    errors++;
    $display("FAIL watchdog timeout");
    finish_run();
  end
endmodule